// File: doc/BRIEF.md
# Cascadable Moving-Sum Result Filter

This block sits behind a four-channel converter result stream and holds two configurable result filters. Each filter takes the results it accepts from a selectable source and keeps a short history of earlier accepted inputs. It produces a final result equal to the newest input plus up to three earlier ones. The per-filter control fields are read every cycle. One field sets the number of summed values and the other sets the input source or disables the filter.

The second filter can be cascaded so that it accepts the first filter's final results instead of raw converter data. That makes a two-stage sum. The second filter sums at most two values, so its history is one register deep and its result is one bit wider than its 12-bit input path. Each filter has its own synchronous clear, which zeroes its history and its final result.

Top module: `moving_sum_filter_pair`

## Requirements
- R1: Length code 00 makes the final result equal to the accepted input.
- R2: Length code 01 makes the final result the accepted input plus the previously accepted input.
- R3: On filter A, length code 10 sums the accepted input and the two previous inputs. Length code 11 sums the accepted input and the three previous inputs.
- R4: Select code 001 accepts a result from any channel whenever `resValid` is high.
- R5: Select codes 100, 101, 110 and 111 accept only results whose `resChan` equals 0, 1, 2 and 3 respectively.
- R6: Select codes 000 and 011 on either filter, and code 010 on filter A, accept nothing. The final result holds, the valid strobe stays low, and the history is kept for later sums.
- R7: Select code 010 on filter B takes filter A's final result as its input. It accepts that result in the cycle in which `sumValidA` is high.
- R8: Filter B treats length codes 10 and 11 as code 01.
- R9: A high clear input, or `rstN` low, zeroes that filter's history and final result with no valid strobe. A clear takes priority over an input accepted in the same cycle.
- R10: An input accepted at a clock edge shows up in the sum and valid outputs right after that edge. The valid strobe lasts one cycle for each accepted input.
- R11: Filter A's 12-bit result cannot overflow: four inputs of 1023 give 4092. Filter B's 13-bit result holds twice 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resValid | input | 1 | Converter result strobe |
| resChan | input | 2 | Channel index of the result |
| resData | input | 10 | Unsigned conversion result |
| lenCfgA | input | 2 | Filter A length code |
| selCfgA | input | 3 | Filter A input select code |
| clrA | input | 1 | Filter A synchronous clear |
| lenCfgB | input | 2 | Filter B length code |
| selCfgB | input | 3 | Filter B input select code |
| clrB | input | 1 | Filter B synchronous clear |
| sumA | output | 12 | Filter A final result |
| sumValidA | output | 1 | Filter A new-result strobe |
| sumB | output | 13 | Filter B final result |
| sumValidB | output | 1 | Filter B new-result strobe |

## Verification
A wrong history register does not show up at the ports until a long enough sum reads it. A bad oldest entry, for example, is hidden until length code 11 is selected and the next input is accepted. The bench therefore changes length codes while inputs are streaming. A wrong acceptance decode shows up in the cycle after the edge as a missing or extra valid strobe, and on filter B one cycle after that. Any state a disabled period corrupts shows up in the first sum after the filter is enabled again.

// File: rtl/msf_pkg.sv
package msf_pkg;
  // strobes from the control decode to the datapath
  typedef struct packed {
    logic       take;      // accept the selected input at this edge
    logic       clear;     // zero history and result
    logic       useChain;  // input comes from the upstream filter
    logic [1:0] lenEff;    // number of history terms added
  } filtStrobe_t;

  localparam logic [2:0] SEL_OFF   = 3'b000;
  localparam logic [2:0] SEL_ANY   = 3'b001;
  localparam logic [2:0] SEL_CHAIN = 3'b010;
  localparam logic [2:0] SEL_RSVD  = 3'b011;
endpackage

// File: rtl/msf_ctrl.sv
module msf_ctrl
  import msf_pkg::*;
#(
  parameter bit CanChain = 1'b0,
  parameter int MaxLen   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        resValid,
  input  logic [1:0]  resChan,
  input  logic [2:0]  selCfg,
  input  logic [1:0]  lenCfg,
  input  logic        clr,
  input  logic        upValid,
  output filtStrobe_t st
);
  localparam logic [1:0] LenTop = 2'(MaxLen - 1);

  logic takeNow;

  always_comb begin
    takeNow = 1'b0;
    unique case (selCfg)
      SEL_ANY:   takeNow = resValid;
      SEL_CHAIN: takeNow = CanChain && upValid;
      SEL_OFF, SEL_RSVD: takeNow = 1'b0;
      default:   takeNow = resValid && (resChan == selCfg[1:0]);
    endcase
  end

  always_comb begin
    st.take     = takeNow;
    st.clear    = clr;
    st.useChain = CanChain && (selCfg == SEL_CHAIN);
    st.lenEff   = (lenCfg > LenTop) ? LenTop : lenCfg;
  end

  a_r4_take_source: assert property (@(posedge clk) disable iff (!rstN)
    st.take |-> (resValid || (CanChain && upValid)));
  a_r6_no_take_off: assert property (@(posedge clk) disable iff (!rstN)
    (selCfg == SEL_OFF || selCfg == SEL_RSVD) |-> !st.take);
  a_r8_len_limit: assert property (@(posedge clk) disable iff (!rstN)
    st.lenEff <= LenTop);
endmodule

// File: rtl/msf_datapath.sv
module msf_datapath
  import msf_pkg::*;
#(
  parameter int InW   = 10,
  parameter int OutW  = 12,
  parameter int Depth = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  filtStrobe_t     st,
  input  logic [InW-1:0]  rawData,
  input  logic [InW-1:0]  upData,
  output logic [OutW-1:0] sumOut,
  output logic            sumValid
);
  logic [InW-1:0]  hist [Depth];
  logic [InW-1:0]  inVal;
  logic [OutW-1:0] sumNext;

  assign inVal = st.useChain ? upData : rawData;

  always_comb begin
    sumNext = OutW'(inVal);
    for (int i = 0; i < Depth; i++) begin
      if (i < int'(st.lenEff)) sumNext = sumNext + OutW'(hist[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumOut   <= '0;
      sumValid <= 1'b0;
    end else if (st.clear) begin
      sumOut   <= '0;
      sumValid <= 1'b0;
    end else begin
      sumValid <= st.take;
      if (st.take) sumOut <= sumNext;
    end
  end

  for (genvar g = 0; g < Depth; g++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         hist[g] <= '0;
      else if (st.clear) hist[g] <= '0;
      else if (st.take)  hist[g] <= (g == 0) ? inVal : hist[(g == 0) ? 0 : g - 1];
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!st.take && !st.clear) |=> ($stable(sumOut) && !sumValid));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> (sumOut == '0 && !sumValid));
  a_r1_pass: assert property (@(posedge clk) disable iff (!rstN)
    (st.take && !st.clear && st.lenEff == 2'd0) |=> (sumOut == OutW'($past(inVal))));
  a_r10_strobe: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> $past(st.take));
endmodule

// File: rtl/moving_sum_filter_pair.sv
module moving_sum_filter_pair
  import msf_pkg::*;
#(
  parameter int DataW = 10,
  parameter int ChanW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [ChanW-1:0]  resChan,
  input  logic [DataW-1:0]  resData,
  input  logic [1:0]        lenCfgA,
  input  logic [2:0]        selCfgA,
  input  logic              clrA,
  input  logic [1:0]        lenCfgB,
  input  logic [2:0]        selCfgB,
  input  logic              clrB,
  output logic [DataW+1:0]  sumA,
  output logic              sumValidA,
  output logic [DataW+2:0]  sumB,
  output logic              sumValidB
);
  localparam int AOutW = DataW + 2;
  localparam int BInW  = AOutW;
  localparam int BOutW = BInW + 1;

  filtStrobe_t stA, stB;

  msf_ctrl #(.CanChain(1'b0), .MaxLen(4)) u_ctrlA (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .selCfg(selCfgA), .lenCfg(lenCfgA), .clr(clrA), .upValid(1'b0), .st(stA));

  msf_datapath #(.InW(DataW), .OutW(AOutW), .Depth(3)) u_dpA (
    .clk(clk), .rstN(rstN), .st(stA), .rawData(resData), .upData('0),
    .sumOut(sumA), .sumValid(sumValidA));

  msf_ctrl #(.CanChain(1'b1), .MaxLen(2)) u_ctrlB (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .selCfg(selCfgB), .lenCfg(lenCfgB), .clr(clrB), .upValid(sumValidA), .st(stB));

  msf_datapath #(.InW(BInW), .OutW(BOutW), .Depth(1)) u_dpB (
    .clk(clk), .rstN(rstN), .st(stB), .rawData(BInW'(resData)), .upData(sumA),
    .sumOut(sumB), .sumValid(sumValidB));

  a_r7_chain_timing: assert property (@(posedge clk) disable iff (!rstN)
    (selCfgB == 3'b010 && !clrB && sumValidA) |=> (sumValidB && sumB == BOutW'($past(sumA))
      + BOutW'(($past(lenCfgB) != 2'd0) ? $past(u_dpB.hist[0]) : '0)));
endmodule

// File: tb/moving_sum_filter_pair_bench.sv
module moving_sum_filter_pair_bench;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic resValid = 1'b0;
  logic [1:0] resChan = '0;
  logic [9:0] resData = '0;
  logic [1:0] lenCfgA = '0, lenCfgB = '0;
  logic [2:0] selCfgA = '0, selCfgB = '0;
  logic clrA = 1'b0, clrB = 1'b0;
  logic [11:0] sumA;
  logic sumValidA;
  logic [12:0] sumB;
  logic sumValidB;

  int errors = 0, checks = 0;
  string tagA = "", tagB = "";

  // bench model state
  int hA[3], hB, mSumA, mSumB;
  bit mValA, mValB;

  always #(ClkPeriod/2) clk = ~clk;

  moving_sum_filter_pair u_moving_sum_filter_pair (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan), .resData(resData),
    .lenCfgA(lenCfgA), .selCfgA(selCfgA), .clrA(clrA),
    .lenCfgB(lenCfgB), .selCfgB(selCfgB), .clrB(clrB),
    .sumA(sumA), .sumValidA(sumValidA), .sumB(sumB), .sumValidB(sumValidB));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit accepts(logic [2:0] sel, bit chainable, bit upV);
    case (sel)
      3'b001:        return resValid;
      3'b010:        return chainable && upV;
      3'b000, 3'b011: return 1'b0;
      default:       return resValid && (resChan == sel[1:0]);
    endcase
  endfunction

  function automatic string autoTag(bit clr, bit take, int len);
    if (clr) return "R9";
    if (!take) return "R6";
    if (len == 0) return "R1";
    if (len == 1) return "R2";
    return "R3";
  endfunction

  // one clock: model update from the driven inputs, edge, compare
  task automatic step();
    bit takeA, takeB;
    int lenB, inB, s, tA, tB;
    string ta, tb;
    takeA = accepts(selCfgA, 1'b0, 1'b0);
    takeB = accepts(selCfgB, 1'b1, mValA);
    lenB = (lenCfgB > 2'd1) ? 1 : int'(lenCfgB);
    inB = (selCfgB == 3'b010) ? mSumA : int'(resData);
    tb = (tagB != "") ? tagB : autoTag(clrB, takeB, lenB);
    ta = (tagA != "") ? tagA : autoTag(clrA, takeA, int'(lenCfgA));
    // filter B first: it sees A's outputs from before the edge
    if (clrB) begin hB = 0; mSumB = 0; mValB = 0; end
    else begin
      mValB = takeB;
      if (takeB) begin
        mSumB = inB + ((lenB == 1) ? hB : 0);
        hB = inB;
      end
    end
    if (clrA) begin hA = '{0, 0, 0}; mSumA = 0; mValA = 0; end
    else begin
      mValA = takeA;
      if (takeA) begin
        s = int'(resData);
        for (int i = 0; i < int'(lenCfgA); i++) s += hA[i];
        mSumA = s;
        hA[2] = hA[1]; hA[1] = hA[0]; hA[0] = int'(resData);
      end
    end
    @(posedge clk); #1;
    tA = int'(sumA); tB = int'(sumB);
    check(ta, "sumA", tA, mSumA);
    check(ta, "sumValidA", int'(sumValidA), int'(mValA));
    check(tb, "sumB", tB, mSumB);
    check(tb, "sumValidB", int'(sumValidB), int'(mValB));
    @(negedge clk);
  endtask

  task automatic feed(int ch, int d);
    resValid = 1'b1; resChan = 2'(ch); resData = 10'(d);
    step();
    resValid = 1'b0;
  endtask

  initial begin
    #(ClkPeriod * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    hA = '{0, 0, 0}; hB = 0; mSumA = 0; mSumB = 0; mValA = 0; mValB = 0;
    repeat (3) @(negedge clk);
    check("R9", "reset sumA", int'(sumA), 0);
    check("R9", "reset sumB", int'(sumB), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11: four maximal inputs on A
    selCfgA = 3'b001; lenCfgA = 2'b11; tagA = "R11";
    repeat (4) feed(1, 1023);
    tagA = "R10"; step();            // strobe drops after one cycle
    tagA = "R9"; clrA = 1'b1; feed(0, 5); clrA = 1'b0;
    // R4: any channel accepted
    tagA = "R4"; lenCfgA = 2'b01;
    for (int c = 0; c < 4; c++) feed(c, 100 + c);
    // R5: only channel 2
    tagA = "R5"; selCfgA = 3'b110;
    for (int c = 0; c < 4; c++) feed(c, 200 + c);
    // R6: disabled codes keep history
    tagA = "R6";
    selCfgA = 3'b000; feed(2, 7);
    selCfgA = 3'b011; feed(2, 8);
    selCfgA = 3'b010; feed(2, 9);
    selCfgA = 3'b001; lenCfgA = 2'b10; tagA = "R3"; feed(3, 11);
    // R7: B cascaded from A, max A outputs into B
    tagA = ""; tagB = "R7"; selCfgB = 3'b010; lenCfgB = 2'b01; lenCfgA = 2'b11;
    repeat (6) feed(0, 1023);
    tagB = "R11"; step(); step();
    // R8: B with long length codes
    tagB = "R8"; selCfgB = 3'b001; lenCfgB = 2'b11;
    feed(1, 300); feed(2, 301); lenCfgB = 2'b10; feed(0, 302);
    tagA = ""; tagB = "";

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        selCfgA = 3'($urandom); lenCfgA = 2'($urandom);
        selCfgB = 3'($urandom); lenCfgB = 2'($urandom);
      end
      clrA = ($urandom_range(0, 40) == 0);
      clrB = ($urandom_range(0, 40) == 0);
      resValid = $urandom_range(0, 2) != 0;
      resChan = 2'($urandom);
      resData = ($urandom_range(0, 7) == 0) ? 10'd1023 : 10'($urandom);
      step();
    end
    clrA = 0; clrB = 0; resValid = 0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule